// File: doc/BRIEF.md
# Opcode-Steered Multi-Lane SPI Master

This block is a half-duplex SPI master. It moves between one and `MAX_BYTES` data bytes per command, on one, two or four data lines. The host issues a command with a valid/ready handshake. The command holds an 8-bit opcode, a byte count and a packed vector of write bytes. There is no mode register. The opcode alone sets the transfer direction and the number of lanes, so one command word fully sets how the bus is driven.

A transfer runs in this order:

1. Chip select goes low.
2. The opcode is shifted out on IO0 alone.
3. For a read only, one turnaround clock follows, during which every line is released.
4. The data phase moves the bytes, first byte first and most significant bits first.

The payload is either driven onto the active lanes or sampled from them, never both. When the transfer ends, chip select rises and a one-cycle done pulse is raised. For a read, the received bytes are presented as a packed vector at that point. A command that cannot be executed is refused with a one-cycle error pulse. The bus is never touched in that case.

Top module: `mioSpiMaster`

## Requirements
- R1: The opcode selects the transfer. 0x0B is a read on one lane, 0x02 a write on one lane, 0xBB a read on two lanes, 0xB2 a write on two lanes, 0xEB a read on four lanes and 0xE2 a write on four lanes.
- R2: Any other opcode, or a byte count of 0 or above `MAX_BYTES`, is refused. `err` pulses for one cycle in the cycle after the request is taken, `csN` stays high, no SCLK edge occurs and no `done` follows.
- R3: After `csN` falls, the opcode is sent most significant bit first, one bit per SCLK, on IO0. During this phase `ioOe` is 4'b0001.
- R4: In a write data phase, write byte k is taken from `reqWrData[8k+7:8k]`. Byte 0 is sent first. Each SCLK carries 1, 2 or 4 bits on IO0, IO1:IO0 or IO3:IO0, with the earliest bit on the highest-numbered lane. `ioOe` is 4'b0001, 4'b0011 or 4'b1111, and the unused lanes are never enabled.
- R5: In a read, the SCLK right after the opcode is a turnaround with `ioOe` at zero. `ioOe` stays zero for the rest of the transfer.
- R6: Read data is sampled on `ioIn` at each rising SCLK of the data phase, using the same lane order as R4. At `done`, byte k of `rdData` is the k-th received byte, and bytes at or above the count are zero. A write leaves `rdData` unchanged.
- R7: SPI mode 0 is used. SCLK is low whenever `csN` is high. `ioOut` and `ioOe` change only together with a falling SCLK or while SCLK is low.
- R8: Each SCLK half period lasts `HALF_DIV` clock cycles. A transfer has 8 + (1 if read) + 8·count/lanes rising SCLK edges.
- R9: `csN` rises in the same cycle as a one-cycle `done` pulse. `reqReady` is low while `csN` is low.
- R10: `ioOe` is nonzero only while `csN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Command request |
| reqReady | output | 1 | Block idle, command accepted when valid |
| reqOpcode | input | 8 | Command opcode (direction and lane count) |
| reqCount | input | $clog2(MAX_BYTES+1) | Number of data bytes |
| reqWrData | input | 8·MAX_BYTES | Write bytes, byte 0 in the low bits |
| rdData | output | 8·MAX_BYTES | Read bytes, byte 0 in the low bits |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | One-cycle pulse for a refused command |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Chip select, active low |
| ioOut | output | 4 | Output values of IO3..IO0 |
| ioOe | output | 4 | Per-line output enables |
| ioIn | input | 4 | Input values of IO3..IO0 |

## Verification
The bench builds the block with `MAX_BYTES` = 4 and `HALF_DIV` = 2. With four bytes, a full-width payload fits every lane mode as a whole number of clocks. A count of 5 is still representable, so the over-range refusal can be reached. A half period of two clock cycles separates the SCLK edge from the cycle in which data moves. This makes the half-period length and the hold of the lines across a high SCLK observable, instead of both coinciding with a single clock edge.

// File: rtl/mioSpiPkg.sv
package mioSpiPkg;

  // Enum value doubles as log2 of the lane count
  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } laneMode_t;

  typedef struct packed {
    logic      ok;
    logic      isRead;
    laneMode_t lanes;
  } opDecode_t;

  // Control to datapath strobes
  typedef struct packed {
    logic loadAll;
    logic shiftOp;
    logic shiftData;
    logic capture;
    logic finish;
    logic driveOp;
    logic driveData;
  } strobes_t;

  function automatic opDecode_t decodeOp(input logic [7:0] op);
    opDecode_t d;
    d.ok     = 1'b1;
    d.isRead = 1'b0;
    d.lanes  = LANE_X1;
    case (op)
      8'h0B: begin d.isRead = 1'b1; d.lanes = LANE_X1; end
      8'h02: begin d.isRead = 1'b0; d.lanes = LANE_X1; end
      8'hBB: begin d.isRead = 1'b1; d.lanes = LANE_X2; end
      8'hB2: begin d.isRead = 1'b0; d.lanes = LANE_X2; end
      8'hEB: begin d.isRead = 1'b1; d.lanes = LANE_X4; end
      8'hE2: begin d.isRead = 1'b0; d.lanes = LANE_X4; end
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mioSpiCtrl.sv
module mioSpiCtrl
  import mioSpiPkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int HALF_DIV  = 2,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int BC_W      = $clog2(MAX_BYTES * 8 + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [7:0]       reqOpcode,
  input  logic [CNT_W-1:0] reqCount,
  output logic             reqReady,
  output logic             sclk,
  output logic             csN,
  output logic             done,
  output logic             err,
  output laneMode_t        lanes,
  output strobes_t         stb
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_OPC, S_TURN, S_DATA, S_FIN
  } state_t;

  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic [BC_W-1:0]  bitCnt;
  logic [BC_W-1:0]  dataClk;
  logic [CNT_W-1:0] cntR;
  logic             readR;
  logic             tick, rise, fall, lastBit;
  logic             countOk, accept, reject;
  opDecode_t        dec;

  always_comb begin
    dec     = decodeOp(reqOpcode);
    countOk = (reqCount != '0) && (reqCount <= CNT_W'(MAX_BYTES));
    accept  = (state == S_IDLE) && reqValid && dec.ok && countOk;
    reject  = (state == S_IDLE) && reqValid && !(dec.ok && countOk);
    tick    = (divCnt == DIV_W'(HALF_DIV - 1));
    rise    = tick && !sclk;
    fall    = tick && sclk;
    lastBit = (bitCnt == BC_W'(1));
    dataClk = (BC_W'(cntR) << 3) >> lanes;
    reqReady = (state == S_IDLE);
  end

  always_comb begin
    stb.loadAll   = accept;
    stb.shiftOp   = (state == S_OPC) && fall && !lastBit;
    stb.shiftData = (state == S_DATA) && fall && !readR && !lastBit;
    stb.capture   = (state == S_DATA) && rise && readR;
    stb.finish    = (state == S_DATA) && fall && readR && lastBit;
    stb.driveOp   = (state == S_START) || (state == S_OPC);
    stb.driveData = (state == S_DATA) && !readR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (state == S_IDLE || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      sclk   <= 1'b0;
      csN    <= 1'b1;
      done   <= 1'b0;
      err    <= 1'b0;
      bitCnt <= '0;
      cntR   <= '0;
      readR  <= 1'b0;
      lanes  <= LANE_X1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state <= S_START;
            csN   <= 1'b0;
            cntR  <= reqCount;
            readR <= dec.isRead;
            lanes <= dec.lanes;
          end else if (reject) begin
            err <= 1'b1;
          end
        end
        S_START: begin
          if (tick) begin
            sclk   <= 1'b1;
            state  <= S_OPC;
            bitCnt <= BC_W'(8);
          end
        end
        S_OPC: begin
          if (rise) sclk <= 1'b1;
          if (fall) begin
            sclk <= 1'b0;
            if (lastBit) begin
              state  <= readR ? S_TURN : S_DATA;
              bitCnt <= readR ? BC_W'(1) : dataClk;
            end else begin
              bitCnt <= bitCnt - BC_W'(1);
            end
          end
        end
        S_TURN: begin
          if (rise) sclk <= 1'b1;
          if (fall) begin
            sclk   <= 1'b0;
            state  <= S_DATA;
            bitCnt <= dataClk;
          end
        end
        S_DATA: begin
          if (rise) sclk <= 1'b1;
          if (fall) begin
            sclk <= 1'b0;
            if (lastBit) state <= S_FIN;
            else         bitCnt <= bitCnt - BC_W'(1);
          end
        end
        S_FIN: begin
          if (tick) begin
            csN   <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mioSpiDatapath.sv
module mioSpiDatapath
  import mioSpiPkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int DATA_W    = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  laneMode_t         lanes,
  input  logic [7:0]        reqOpcode,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [DATA_W-1:0] rdData
);

  logic [7:0]        opShift;
  logic [DATA_W-1:0] wrShift, wrOrdered;
  logic [DATA_W-1:0] rdShift, rdOrdered;
  logic [CNT_W-1:0]  cntR;

  // Byte 0 goes to the top so it leaves first
  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) begin
      wrOrdered[DATA_W-1-i*8 -: 8] = reqWrData[i*8 +: 8];
    end
  end

  // First received byte sits highest in the used part of rdShift
  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) begin
      rdOrdered[i*8 +: 8] = (i < int'(cntR))
                          ? 8'(rdShift >> (8 * (int'(cntR) - 1 - i)))
                          : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opShift <= '0;
      wrShift <= '0;
      rdShift <= '0;
      cntR    <= '0;
      rdData  <= '0;
    end else begin
      if (stb.loadAll) begin
        opShift <= reqOpcode;
        wrShift <= wrOrdered;
        rdShift <= '0;
        cntR    <= reqCount;
      end
      if (stb.shiftOp) opShift <= {opShift[6:0], 1'b0};
      if (stb.shiftData) begin
        case (lanes)
          LANE_X2: wrShift <= wrShift << 2;
          LANE_X4: wrShift <= wrShift << 4;
          default: wrShift <= wrShift << 1;
        endcase
      end
      if (stb.capture) begin
        case (lanes)
          LANE_X2: rdShift <= {rdShift[DATA_W-3:0], ioIn[1:0]};
          LANE_X4: rdShift <= {rdShift[DATA_W-5:0], ioIn};
          default: rdShift <= {rdShift[DATA_W-2:0], ioIn[0]};
        endcase
      end
      if (stb.finish) rdData <= rdOrdered;
    end
  end

  always_comb begin
    ioOut = 4'h0;
    ioOe  = 4'h0;
    if (stb.driveOp) begin
      ioOut = {3'b000, opShift[7]};
      ioOe  = 4'b0001;
    end else if (stb.driveData) begin
      case (lanes)
        LANE_X2: begin ioOut = {2'b00, wrShift[DATA_W-1 -: 2]}; ioOe = 4'b0011; end
        LANE_X4: begin ioOut = wrShift[DATA_W-1 -: 4];          ioOe = 4'b1111; end
        default: begin ioOut = {3'b000, wrShift[DATA_W-1]};     ioOe = 4'b0001; end
      endcase
    end
  end

endmodule

// File: rtl/mioSpiMaster.sv
module mioSpiMaster
  import mioSpiPkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int HALF_DIV  = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [7:0]                       reqOpcode,
  input  logic [$clog2(MAX_BYTES+1)-1:0]   reqCount,
  input  logic [MAX_BYTES*8-1:0]           reqWrData,
  output logic [MAX_BYTES*8-1:0]           rdData,
  output logic                             done,
  output logic                             err,
  output logic                             sclk,
  output logic                             csN,
  output logic [3:0]                       ioOut,
  output logic [3:0]                       ioOe,
  input  logic [3:0]                       ioIn
);

  localparam int CNT_W  = $clog2(MAX_BYTES + 1);
  localparam int BC_W   = $clog2(MAX_BYTES * 8 + 1);
  localparam int DATA_W = MAX_BYTES * 8;

  strobes_t  stb;
  laneMode_t lanes;

  mioSpiCtrl #(
    .MAX_BYTES(MAX_BYTES), .HALF_DIV(HALF_DIV), .CNT_W(CNT_W), .BC_W(BC_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqCount(reqCount), .reqReady(reqReady), .sclk(sclk), .csN(csN),
    .done(done), .err(err), .lanes(lanes), .stb(stb)
  );

  mioSpiDatapath #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lanes(lanes), .reqOpcode(reqOpcode),
    .reqCount(reqCount), .reqWrData(reqWrData), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .rdData(rdData)
  );

endmodule

// File: rtl/mioSpiChecker.sv
module mioSpiChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       done,
  input logic       err,
  input logic       sclk,
  input logic       csN,
  input logic [3:0] ioOut,
  input logic [3:0] ioOe
);

  assert_err_bus_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    err |-> csN);

  assert_oe_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000) || (ioOe == 4'b0001) || (ioOe == 4'b0011) || (ioOe == 4'b1111));

  assert_sclk_idle_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_lines_hold_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> ($stable(ioOut) && $stable(ioOe)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_with_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN)));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !reqReady);

  assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe != 4'b0000) |-> !csN);

endmodule

bind mioSpiMaster mioSpiChecker u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .done(done), .err(err),
  .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe)
);

// File: tb/mioSpiMaster_tb.sv
module mioSpiMaster_tb;

  localparam int MAXB  = 4;
  localparam int HDIV  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqOpcode = 8'h00;
  logic [2:0]  reqCount = 3'd0;
  logic [31:0] reqWrData = 32'h0;
  logic [31:0] rdData;
  logic        done, err, sclk, csN;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  ioIn = 4'h0;

  int nChecks = 0;
  int nFails  = 0;

  // Per-rising-SCLK expectations
  logic [3:0]  qOe[$], qOut[$], qIn[$];
  // Per-transaction expectations
  bit          txErr[$];
  bit          txRead[$];
  logic [31:0] txRd[$];
  int          txRises[$];
  logic [31:0] lastRd = 32'h0;

  always #5 clk = ~clk;

  mioSpiMaster #(.MAX_BYTES(MAXB), .HALF_DIV(HDIV)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOpcode(reqOpcode), .reqCount(reqCount), .reqWrData(reqWrData),
    .rdData(rdData), .done(done), .err(err), .sclk(sclk), .csN(csN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected bus trace and outcome, then issues the command
  task automatic doTxn(input logic [7:0] op, input int cnt, input logic [31:0] wr,
                       input logic [31:0] dev);
    bit   bad = 1'b0;
    bit   rd  = 1'b0;
    int   L   = 1;
    int   rises = 0;
    logic [31:0] src, expRd;
    case (op)
      8'h0B: begin rd = 1; L = 1; end
      8'h02: begin rd = 0; L = 1; end
      8'hBB: begin rd = 1; L = 2; end
      8'hB2: begin rd = 0; L = 2; end
      8'hEB: begin rd = 1; L = 4; end
      8'hE2: begin rd = 0; L = 4; end
      default: bad = 1;
    endcase
    if (cnt == 0 || cnt > MAXB) bad = 1;
    if (bad) begin
      txErr.push_back(1'b1); txRead.push_back(1'b0);
      txRd.push_back(lastRd); txRises.push_back(0);
    end else begin
      for (int k = 0; k < 8; k++) begin
        qOe.push_back(4'b0001); qOut.push_back({3'b000, op[7-k]}); qIn.push_back(4'h0);
        rises++;
      end
      if (rd) begin
        qOe.push_back(4'b0000); qOut.push_back(4'h0); qIn.push_back(4'h0);
        rises++;
      end
      src = rd ? dev : wr;
      for (int j = 0; j < cnt * 8 / L; j++) begin
        logic [3:0] v = 4'h0;
        for (int m = 0; m < L; m++) begin
          int p = j * L + m;
          v[L-1-m] = src[(p / 8) * 8 + 7 - (p % 8)];
        end
        if (rd) begin
          qOe.push_back(4'b0000); qOut.push_back(4'h0); qIn.push_back(v);
        end else begin
          qOe.push_back(L == 1 ? 4'b0001 : (L == 2 ? 4'b0011 : 4'b1111));
          qOut.push_back(v); qIn.push_back(4'h0);
        end
        rises++;
      end
      if (rd) begin
        expRd = 32'h0;
        for (int i = 0; i < cnt; i++) expRd[i*8 +: 8] = dev[i*8 +: 8];
        lastRd = expRd;
      end
      txErr.push_back(1'b0); txRead.push_back(rd);
      txRd.push_back(lastRd); txRises.push_back(rises);
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqOpcode = op;
    reqCount  = 3'(cnt);
    reqWrData = wr;
    @(negedge clk);
    reqValid = 1'b0;
    while (txErr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: device model and scoreboard
  logic prevSclk = 1'b0;
  int   highCnt  = 0;
  int   riseCnt  = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sclk && !prevSclk) begin
        if (qOe.size() == 0) begin
          check(1'b0, "R2 unexpected SCLK rise", 64'(sclk), 64'(0));
        end else begin
          logic [3:0] eOe, eOut, eIn;
          string tag;
          eOe = qOe.pop_front(); eOut = qOut.pop_front(); eIn = qIn.pop_front();
          tag = (riseCnt < 8) ? "R3 opcode lane" :
                ((txRead.size() != 0 && txRead[0]) ? "R5 released lines on read" :
                                                     "R4 write lanes");
          check((ioOe == eOe) && ((ioOut & ioOe) == (eOut & eOe)), tag,
                64'({ioOe, ioOut}), 64'({eOe, eOut & eOe}));
        end
        riseCnt++;
      end
      if (sclk) highCnt++;
      if (!sclk && prevSclk) begin
        check(highCnt == HDIV, "R8 SCLK high half period", 64'(highCnt), 64'(HDIV));
        ioIn = (qIn.size() != 0) ? qIn[0] : 4'h0;
      end
      if (!sclk) highCnt = 0;
      if (done || err) begin
        if (txErr.size() == 0) begin
          check(1'b0, "R9 completion without command", 64'({done, err}), 64'(0));
        end else begin
          bit eErr; bit eRd; logic [31:0] eData; int eRises;
          eErr = txErr.pop_front(); eRd = txRead.pop_front();
          eData = txRd.pop_front(); eRises = txRises.pop_front();
          check(err == eErr && done == !eErr, eErr ? "R2 refusal flag" : "R1 accepted opcode",
                64'({done, err}), 64'({!eErr, eErr}));
          check(riseCnt == eRises, "R8 SCLK rise count", 64'(riseCnt), 64'(eRises));
          check(csN == 1'b1, "R9 chip select released", 64'(csN), 64'(1));
          check(rdData == eData, eRd ? "R6 read bytes" : "R6 read bytes kept",
                64'(rdData), 64'(eData));
        end
        riseCnt = 0;
      end
    end
    prevSclk = sclk;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && reqReady == 1'b1, "R9 reset idle", 64'({csN, reqReady}), 64'(3));
    check(sclk == 1'b0, "R7 reset SCLK low", 64'(sclk), 64'(0));
    check(ioOe == 4'h0, "R10 reset lines released", 64'(ioOe), 64'(0));
    check(done == 1'b0 && err == 1'b0 && rdData == 32'h0, "R6 reset outputs",
          64'({done, err, rdData}), 64'(0));

    doTxn(8'h02, 1, 32'h0000_00A5, 32'h0);          // single write
    doTxn(8'h0B, 2, 32'h0, 32'hFFFF_C33C);          // single read, upper bytes zero
    doTxn(8'hB2, 3, 32'h0012_6E9D, 32'h0);          // dual write
    doTxn(8'hBB, 4, 32'h0, 32'h8421_5AF0);          // dual read full width
    doTxn(8'hE2, 4, 32'hDEAD_BEEF, 32'h0);          // quad write, rdData kept
    doTxn(8'hEB, 1, 32'h0, 32'h7777_77B6);          // quad read one byte
    doTxn(8'h03, 2, 32'h1234_5678, 32'h0);          // unknown opcode
    doTxn(8'h02, 0, 32'h1234_5678, 32'h0);          // zero count
    doTxn(8'hEB, 5, 32'h0, 32'h0);                  // count above limit
    doTxn(8'hEB, 4, 32'h0, 32'h0F1E_2D3C);          // quad read full width
    doTxn(8'h0B, 4, 32'h0, 32'h8000_0001);          // single read full width
    doTxn(8'hE2, 1, 32'h0000_005A, 32'h0);

    check(qOe.size() == 0 && txErr.size() == 0, "R8 all expected edges seen",
          64'(qOe.size()), 64'(0));
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule